// File: doc/BRIEF.md
# Saturating Fixed-Point DSP ALU

This block is the arithmetic and logic stage of a DSP datapath. Each 40-bit operand can be read three ways. The first is a fixed-point value: 32 bits in [31:0], with 8 guard bits in [39:32] above them. The second is an integer field in the upper part of the word. The third is a 16-bit logical field in [31:16]. A per-operation mode input chooses the width of the arithmetic. With guard bits, it works on the full 40-bit word, or on a 24-bit integer in [39:16]. Without guard bits, it works on 32 bits, or on a 16-bit integer in [31:16].

The supported operations are:
- add, subtract and compare on the fixed-point view;
- increment and decrement on the integer view;
- AND, OR and XOR on the logical view.

A saturation input replaces an overflowing result with the largest or smallest value of the target width. A condition flag reports overflow, the compare outcome or a zero logical result. An operation marked conditional runs only while that flag is set, and it never changes the flag.

The destination value and the flag are registered outputs. Both are updated on the rising edge that samples an issued operation.

Top module: `dsp_sat_alu`

## Requirements
- R1: After reset `dst_q` is 0 and `dc_q` is 0.
- R2: Opcode 0 adds and opcode 1 subtracts (a minus b). With `guard_en`=1 the operation uses all 40 bits and the result wraps in 40 bits. `dc_q` is 1 when the exact result lies outside the signed 32-bit range.
- R3: With `guard_en`=0, fixed-point operations use only a[31:0] and b[31:0] as signed 32-bit values. The result wraps in 32 bits and is sign-extended into [39:32]. `dc_q` reports signed 32-bit overflow.
- R4: With `sat_en`=1, an overflowing add or subtract stores 0x00_7FFF_FFFF for a positive overflow and 0xFF_8000_0000 for a negative one, with `dc_q`=1. A result that does not overflow is stored unchanged.
- R5: Opcode 3 adds 1 and opcode 4 subtracts 1 on the integer field. That field is [39:16] (24 bits) with `guard_en`=1 and [31:16] (16 bits) with `guard_en`=0. Bits [15:0] of the result are 0. Without guard bits the field is sign-extended into [39:32]. `dc_q` is 1 on signed 16-bit overflow. When `sat_en`=1 such an overflow stores 0x00_7FFF_0000 or 0xFF_8000_0000. Otherwise the field wraps in its own width.
- R6: Opcodes 5, 6 and 7 form a[31:16] AND, OR and XOR b[31:16], respectively. The result is stored in [31:16], with [39:32] and [15:0] cleared. `dc_q` is 1 exactly when the 16-bit result is zero.
- R7: Opcode 2 compares the two operands at the width chosen by `guard_en`. It sets `dc_q` to 1 when a is greater than or equal to b (signed) and leaves `dst_q` unchanged.
- R8: With `cond_en`=1 an operation executes only when `dc_q` is 1, and `dc_q` is never changed by it. With `dc_q`=0 neither output changes.
- R9: While `op_valid` is 0, `dst_q` and `dc_q` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue an operation this cycle |
| opcode | input | 3 | Operation code, see R2 to R7 |
| guard_en | input | 1 | 1: arithmetic includes guard bits |
| sat_en | input | 1 | 1: clamp overflowing arithmetic |
| cond_en | input | 1 | 1: execute only while the flag is set |
| a | input | 40 | First operand |
| b | input | 40 | Second operand |
| dst_q | output | 40 | Registered destination value |
| dc_q | output | 1 | Registered condition flag |

## Verification
Every result is due one cycle after issue. The destination value and the flag are updated on the first rising edge that sees `op_valid` high, and neither changes again until the next issued operation. The bench drives each operation on a falling edge and removes it on the next falling edge. It reads `dst_q` and `dc_q` at that second falling edge, half a period after the capturing edge. For held, skipped and compare-only cases, the bench first reads the outputs and then confirms that they are unchanged at that same point.

// File: rtl/dsp_sat_alu.sv
module dsp_sat_alu #(
  parameter int GW = 8,
  parameter int FW = 32,
  parameter int IW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        opcode,
  input  logic              guard_en,
  input  logic              sat_en,
  input  logic              cond_en,
  input  logic [GW+FW-1:0]  a,
  input  logic [GW+FW-1:0]  b,
  output logic [GW+FW-1:0]  dst_q,
  output logic              dc_q
);
  localparam int W   = GW + FW;
  localparam int LW  = FW - IW;
  localparam int IWG = GW + IW;
  localparam logic [W-1:0] FMAX = {{(GW+1){1'b0}}, {(FW-1){1'b1}}};
  localparam logic [W-1:0] FMIN = {{(GW+1){1'b1}}, {(FW-1){1'b0}}};
  localparam logic [W-1:0] IMAX = {{(GW+1){1'b0}}, {(IW-1){1'b1}}, {LW{1'b0}}};
  localparam logic [W-1:0] IMIN = {{(GW+1){1'b1}}, {(IW-1){1'b0}}, {LW{1'b0}}};

  typedef enum logic [2:0] {
    OP_ADD, OP_SUB, OP_CMP, OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR
  } op_t;

  op_t op;
  assign op = op_t'(opcode);

  logic [W:0] fa, fb, fsum;
  assign fa   = guard_en ? {a[W-1], a} : {{(GW+1){a[FW-1]}}, a[FW-1:0]};
  assign fb   = guard_en ? {b[W-1], b} : {{(GW+1){b[FW-1]}}, b[FW-1:0]};
  assign fsum = (op == OP_ADD) ? fa + fb : fa - fb;

  logic f_ovf;
  assign f_ovf = !((&fsum[W:FW-1]) || !(|fsum[W:FW-1]));

  logic [W-1:0] f_wrap;
  assign f_wrap = guard_en ? fsum[W-1:0] : {{GW{fsum[FW-1]}}, fsum[FW-1:0]};

  logic [IWG:0] ia, isum;
  assign ia   = guard_en ? {a[W-1], a[W-1:LW]} : {{(GW+1){a[FW-1]}}, a[FW-1:LW]};
  assign isum = (op == OP_INC) ? ia + (IWG+1)'(1) : ia - (IWG+1)'(1);

  logic i_ovf;
  assign i_ovf = !((&isum[IWG:IW-1]) || !(|isum[IWG:IW-1]));

  logic [W-1:0] i_wrap;
  assign i_wrap = guard_en ? {isum[IWG-1:0], {LW{1'b0}}}
                           : {{GW{isum[IW-1]}}, isum[IW-1:0], {LW{1'b0}}};

  logic [IW-1:0] lr;
  always_comb begin
    case (op)
      OP_AND:  lr = a[FW-1:LW] & b[FW-1:LW];
      OP_OR:   lr = a[FW-1:LW] | b[FW-1:LW];
      default: lr = a[FW-1:LW] ^ b[FW-1:LW];
    endcase
  end

  logic [W-1:0] nxt_res;
  logic         nxt_dc, wr_res;
  always_comb begin
    nxt_res = '0;
    nxt_dc  = 1'b0;
    wr_res  = 1'b1;
    case (op)
      OP_ADD, OP_SUB: begin
        nxt_dc  = f_ovf;
        nxt_res = (sat_en && f_ovf) ? (fsum[W] ? FMIN : FMAX) : f_wrap;
      end
      OP_CMP: begin
        nxt_dc = !fsum[W];
        wr_res = 1'b0;
      end
      OP_INC, OP_DEC: begin
        nxt_dc  = i_ovf;
        nxt_res = (sat_en && i_ovf) ? (isum[IWG] ? IMIN : IMAX) : i_wrap;
      end
      default: begin
        nxt_dc  = (lr == '0);
        nxt_res = {{GW{1'b0}}, lr, {LW{1'b0}}};
      end
    endcase
  end

  logic go;
  assign go = op_valid && (!cond_en || dc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      dc_q  <= 1'b0;
    end else if (go) begin
      if (wr_res) dst_q <= nxt_res;
      if (!cond_en) dc_q <= nxt_dc;
    end
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(dst_q) && $stable(dc_q)));

  // R8
  cond_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cond_en && !dc_q) |=> ($stable(dst_q) && $stable(dc_q)));

  // R8
  cond_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cond_en) |=> $stable(dc_q));

  // R7
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 3'd2) |=> $stable(dst_q));

  // R6
  logic_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode >= 3'd5 && (!cond_en || dc_q))
    |=> (dst_q[LW-1:0] == '0 && dst_q[W-1:FW] == '0));

  // R4
  sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sat_en && opcode <= 3'd1 && (!cond_en || dc_q))
    |=> ((&dst_q[W-1:FW-1]) || !(|dst_q[W-1:FW-1])));
endmodule

// File: tb/sim_dsp_sat_alu.sv
`timescale 1ns/1ps
module sim_dsp_sat_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  opcode = 3'd0;
  logic        guard_en = 1'b0;
  logic        sat_en = 1'b0;
  logic        cond_en = 1'b0;
  logic [39:0] a = '0;
  logic [39:0] b = '0;
  logic [39:0] dst_q;
  logic        dc_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dsp_sat_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .guard_en(guard_en), .sat_en(sat_en), .cond_en(cond_en),
    .a(a), .b(b), .dst_q(dst_q), .dc_q(dc_q)
  );

  task automatic chk(input string tag, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [39:0] va, input logic [39:0] vb,
                     input logic g, input logic s, input logic c);
    @(negedge clk);
    opcode = op; a = va; b = vb; guard_en = g; sat_en = s; cond_en = c;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic expect_op(input string tag, input logic [2:0] op, input logic [39:0] va,
                           input logic [39:0] vb, input logic g, input logic s,
                           input logic [39:0] er, input logic ed);
    run(op, va, vb, g, s, 1'b0);
    chk({tag, " dst"}, dst_q, er);
    chk({tag, " dc"}, {39'd0, dc_q}, {39'd0, ed});
  endtask

  task automatic t_reset;
    chk("R1 reset dst", dst_q, 40'd0);
    chk("R1 reset dc", {39'd0, dc_q}, 40'd0);
  endtask

  task automatic t_guard_arith;
    expect_op("R2 add small", 3'd0, 40'h00_0000_0005, 40'h00_0000_0003, 1, 0, 40'h00_0000_0008, 0);
    expect_op("R2 add past 32", 3'd0, 40'h00_7FFF_FFFF, 40'h1, 1, 0, 40'h00_8000_0000, 1);
    expect_op("R2 sub neg", 3'd1, 40'h0, 40'h1, 1, 0, 40'hFF_FFFF_FFFF, 0);
    expect_op("R2 add wrap 40", 3'd0, 40'h7F_FFFF_FFFF, 40'h1, 1, 0, 40'h80_0000_0000, 1);
  endtask

  task automatic t_noguard_arith;
    expect_op("R3 add ovf", 3'd0, 40'h12_7FFF_FFFF, 40'h1, 0, 0, 40'hFF_8000_0000, 1);
    expect_op("R3 sub", 3'd1, 40'hAB_0000_0010, 40'h00_0000_0020, 0, 0, 40'hFF_FFFF_FFF0, 0);
  endtask

  task automatic t_saturate;
    expect_op("R4 pos clamp", 3'd0, 40'h00_7FFF_FFFF, 40'h1, 1, 1, 40'h00_7FFF_FFFF, 1);
    expect_op("R4 neg clamp", 3'd1, 40'hFF_8000_0000, 40'h1, 1, 1, 40'hFF_8000_0000, 1);
    expect_op("R4 no-guard clamp", 3'd0, 40'h00_7FFF_FFFF, 40'h00_7FFF_FFFF, 0, 1, 40'h00_7FFF_FFFF, 1);
    expect_op("R4 in range", 3'd0, 40'h5, 40'h3, 1, 1, 40'h8, 0);
  endtask

  task automatic t_integer;
    expect_op("R5 inc guard", 3'd3, 40'h00_0001_1234, 40'h0, 1, 0, 40'h00_0002_0000, 0);
    expect_op("R5 inc ovf", 3'd3, 40'h00_7FFF_0000, 40'h0, 1, 0, 40'h00_8000_0000, 1);
    expect_op("R5 inc sat", 3'd3, 40'h00_7FFF_0000, 40'h0, 1, 1, 40'h00_7FFF_0000, 1);
    expect_op("R5 dec wrap16", 3'd4, 40'h00_8000_0000, 40'h0, 0, 0, 40'h00_7FFF_0000, 1);
    expect_op("R5 dec sat16", 3'd4, 40'h00_8000_0000, 40'h0, 0, 1, 40'hFF_8000_0000, 1);
    expect_op("R5 dec guard", 3'd4, 40'h0, 40'h0, 1, 0, 40'hFF_FFFF_0000, 0);
  endtask

  task automatic t_logic;
    expect_op("R6 and", 3'd5, 40'h55_F0F0_1234, 40'h00_FF00_FFFF, 1, 0, 40'h00_F000_0000, 0);
    expect_op("R6 or", 3'd6, 40'h00_F0F0_0000, 40'h00_0F0F_0000, 0, 0, 40'h00_FFFF_0000, 0);
    expect_op("R6 xor zero", 3'd7, 40'h00_AAAA_0000, 40'h00_AAAA_0000, 1, 0, 40'h0, 1);
  endtask

  task automatic t_compare;
    logic [39:0] keep;
    keep = dst_q;
    expect_op("R7 cmp ge", 3'd2, 40'h5, 40'h3, 1, 0, keep, 1);
    expect_op("R7 cmp lt", 3'd2, 40'h3, 40'h5, 1, 0, keep, 0);
    expect_op("R7 cmp guard", 3'd2, 40'h01_0000_0000, 40'h1, 1, 0, keep, 1);
    expect_op("R7 cmp no-guard", 3'd2, 40'h01_0000_0000, 40'h1, 0, 0, keep, 0);
  endtask

  task automatic t_conditional;
    logic [39:0] keep;
    run(3'd2, 40'h3, 40'h5, 1, 0, 0);
    keep = dst_q;
    run(3'd0, 40'h1, 40'h1, 1, 0, 1);
    chk("R8 skipped dst", dst_q, keep);
    chk("R8 skipped dc", {39'd0, dc_q}, 40'd0);
    run(3'd2, 40'h5, 40'h3, 1, 0, 0);
    run(3'd0, 40'h1, 40'h1, 1, 0, 1);
    chk("R8 taken dst", dst_q, 40'h2);
    chk("R8 taken dc kept", {39'd0, dc_q}, 40'd1);
  endtask

  task automatic t_idle;
    logic [39:0] keep;
    logic kdc;
    keep = dst_q;
    kdc = dc_q;
    @(negedge clk);
    opcode = 3'd0; a = 40'h00_7FFF_FFFF; b = 40'h1; cond_en = 1'b0; op_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 idle dst", dst_q, keep);
    chk("R9 idle dc", {39'd0, dc_q}, {39'd0, kdc});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_guard_arith();
    t_noguard_arith();
    t_saturate();
    t_integer();
    t_logic();
    t_compare();
    t_conditional();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule